// File: doc/BRIEF.md
# Nested Core Event Pending Controller

The block watches a vector of event inputs, one per priority level (sixteen by default). It finds rising edges on them and holds each one in a latch bit. Each event has an enable bit in a mask register. The upper, general-purpose levels are also gated by a global enable. The block picks the most urgent latched event that is allowed to run and that outranks every level already in service. It presents that event's number together with a request strobe.

The core drives an acknowledge when the requested event enters service. The block then sets that event's bit in a pending vector, which records the nesting. The same acknowledge clears the latch bit, so that a later edge on the same input is queued again. A return strobe removes the innermost active level and resumes the next outer one.

Software reaches the latch, mask and pending registers through a simple register port. The port honours only accesses made in supervisor mode.

Top module: `evt_nest_ctrl`

## Requirements
- R1: After reset the latch, mask and pending registers all read as zero, the global enable is off and the request output is low.
- R2: A rising edge on an event input sets that event's latch bit at the second clock edge after the input rises. An input that stays high sets the bit only once.
- R3: A latch bit is set whether or not its mask bit is set. An event with a cleared mask bit is never requested.
- R4: Among the latched events that are allowed, the lowest event number is requested. The request output is high and the event-number output shows that number.
- R5: An event is requested only if its number is lower than every set pending bit.
- R6: An acknowledge while the request is high sets the pending bit of the requested event and clears its latch bit at the same clock edge. With the acknowledge given at once, the pending bit appears at the third clock edge after the input rises.
- R7: A new rising edge on an event that is already pending sets its latch bit again. The event stays queued until it may preempt.
- R8: A return strobe clears only the lowest-numbered set pending bit.
- R9: Events numbered GP_FIRST (default 7) and above are requested only while the global enable is on. A set command turns it on. A clear command turns it off, and the clear wins if both come in the same cycle. Events below GP_FIRST ignore the global enable.
- R10: A supervisor write with select 0 (latch) replaces only those latch bits whose mask bit is clear. Latch bits whose mask bit is set are unchanged.
- R11: A supervisor write with select 1 (mask) replaces the mask. A write with select 2 (pending) has no effect. Select 3 reads as zero.
- R12: Accesses with supervisor low are ignored: writes change nothing and reads return zero. Reads with supervisor high and enable high return the selected register. Any read with enable low returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | NUM_EVT | Event inputs, bit i is priority level i (0 most urgent) |
| ack | input | 1 | Core accepts the requested event this cycle |
| ret | input | 1 | Return from the innermost active event |
| gie_set | input | 1 | Turn the global enable on |
| gie_clr | input | 1 | Turn the global enable off |
| supv | input | 1 | Current access is made in supervisor mode |
| reg_en | input | 1 | Register access valid |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | 0 latch, 1 mask, 2 pending, 3 none |
| reg_wdata | input | NUM_EVT | Write data |
| reg_rdata | output | NUM_EVT | Read data (combinational) |
| req | output | 1 | An event is selected for service |
| req_id | output | IDX_W | Number of the selected event |

## Verification
The assertions assume that the core raises acknowledge only while the request is high. They also assume that acknowledge and return never arrive in the same cycle, and that return is given only while some level is pending. The stimulus drives each of these strobes for a single cycle. It raises acknowledge only after it has seen the request high, and it issues a return only for a level it has acknowledged earlier. Event inputs and register accesses change only between clock edges and last whole cycles, so every edge the detector sees is clean.

// File: rtl/evt_pkg.sv
// Package evt_pkg: shared encodings for the event pending controller.
// Assumes a two-bit register select on the software port.
package evt_pkg;
    typedef enum logic [1:0] {
        SEL_LATCH = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_PEND  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/evt_edge_det.sv
// Module evt_edge_det: two-stage rising edge detector, one bit per event.
// Assumes inputs are synchronous to clk; a held-high input yields one pulse.
module evt_edge_det #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    logic [N-1:0] stg1, stg2;

    // Capture the input and its delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1 <= '0;
            stg2 <= '0;
        end else begin
            stg1 <= din;
            stg2 <= stg1;
        end
    end

    assign rise = stg1 & ~stg2;

    // R2: an edge pulse never lasts two cycles for the same bit
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/evt_find_first.sv
// Module evt_find_first: locates the lowest-numbered set bit of a vector.
// Assumes bit 0 is the most urgent; idx is zero when nothing is set.
module evt_find_first #(
    parameter int N = 16,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/evt_nest_ctrl.sv
// Module evt_nest_ctrl: latches event edges, applies mask and global enable,
// selects the most urgent event able to preempt, and tracks nesting.
// Assumes ack only with req high, ack and ret never together, and ret only
// while a level is pending.
module evt_nest_ctrl #(
    parameter int NUM_EVT  = 16,
    parameter int GP_FIRST = 7,
    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               ack,
    input  logic               ret,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic               supv,
    input  logic               reg_en,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [NUM_EVT-1:0] reg_wdata,
    output logic [NUM_EVT-1:0] reg_rdata,
    output logic               req,
    output logic [IDX_W-1:0]   req_id
);
    import evt_pkg::*;

    logic [NUM_EVT-1:0] latch_q, mask_q, pend_q;
    logic               gie_q;
    logic [NUM_EVT-1:0] rise, en_vec, allow, cand, ack_vec, ret_vec;
    logic [NUM_EVT-1:0] upto_req;
    logic [NUM_EVT-1:0] latch_base;
    logic               pf_found;
    logic [IDX_W-1:0]   pf_idx;
    logic               sw_wr;

    evt_edge_det #(.N(NUM_EVT)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (evt_in),
        .rise (rise)
    );

    evt_find_first #(.N(NUM_EVT)) u_pend_first (
        .vec  (pend_q),
        .found(pf_found),
        .idx  (pf_idx)
    );

    evt_find_first #(.N(NUM_EVT)) u_req_first (
        .vec  (cand),
        .found(req),
        .idx  (req_id)
    );

    // Per-level enables, the preemption window and one-hot strobes.
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_lvl
        assign en_vec[i]   = (i < GP_FIRST) ? 1'b1 : gie_q;
        assign allow[i]    = !pf_found || (IDX_W'(i) < pf_idx);
        assign ack_vec[i]  = ack && req && (req_id == IDX_W'(i));
        assign ret_vec[i]  = ret && pf_found && (pf_idx == IDX_W'(i));
        assign upto_req[i] = (IDX_W'(i) <= req_id);
    end

    assign cand  = latch_q & mask_q & en_vec & allow;
    assign sw_wr = reg_en && reg_wr && supv;

    // Software latch write replaces only the bits whose mask is clear.
    always_comb begin
        latch_base = latch_q;
        if (sw_wr && reg_sel == SEL_LATCH)
            latch_base = (latch_q & mask_q) | (reg_wdata & ~mask_q);
    end

    // Latch, mask and pending state; a new edge wins over an ack clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            mask_q  <= '0;
            pend_q  <= '0;
        end else begin
            latch_q <= (latch_base & ~ack_vec) | rise;
            if (sw_wr && reg_sel == SEL_MASK)
                mask_q <= reg_wdata;
            pend_q  <= (pend_q & ~ret_vec) | ack_vec;
        end
    end

    // Global enable; a clear command takes precedence over set.
    always_ff @(posedge clk) begin
        if (!rst_n)       gie_q <= 1'b0;
        else if (gie_clr) gie_q <= 1'b0;
        else if (gie_set) gie_q <= 1'b1;
    end

    // Read mux, zero for user mode or idle port.
    always_comb begin
        reg_rdata = '0;
        if (reg_en && !reg_wr && supv) begin
            case (reg_sel)
                SEL_LATCH: reg_rdata = latch_q;
                SEL_MASK:  reg_rdata = mask_q;
                SEL_PEND:  reg_rdata = pend_q;
                default:   reg_rdata = '0;
            endcase
        end
    end

    // R3: a requested event is latched and unmasked
    a_r3_req_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (latch_q[req_id] && mask_q[req_id]));

    // R5: no pending level at or below the requested number
    a_r5_preempt_only: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ((pend_q & upto_req) == '0));

    // R6: acknowledge makes the served event pending
    a_r6_ack_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |=> pend_q[$past(req_id)]);

    // R8: a return removes exactly one pending level
    a_r8_ret_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !ack && pf_found) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

    // R11: pending changes only through ack or ret, never from software
    a_r11_pend_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ack && req) && !ret) |=> (pend_q == $past(pend_q)));

    // R12: user-mode reads return zero
    a_r12_user_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !supv) |-> (reg_rdata == '0));
endmodule

// File: tb/tb_evt_nest_ctrl.sv
module tb_evt_nest_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_in = '0;
    logic          ack = 1'b0, ret = 1'b0, gie_set = 1'b0, gie_clr = 1'b0;
    logic          supv = 1'b1, reg_en = 1'b0, reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata;
    logic          req;
    logic [3:0]    req_id;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    evt_nest_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .ack(ack), .ret(ret),
        .gie_set(gie_set), .gie_clr(gie_clr), .supv(supv), .reg_en(reg_en),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req(req), .req_id(req_id)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // {latch, mask, gie, exp_req, exp_id}
    localparam int NV = 7;
    localparam logic [37:0] VEC [NV] = '{
        {16'h0010, 16'hFFFF, 1'b0, 1'b1, 4'd4},
        {16'h0110, 16'hFFEF, 1'b1, 1'b1, 4'd8},
        {16'h0110, 16'hFFEF, 1'b0, 1'b0, 4'd0},
        {16'h8000, 16'h8000, 1'b1, 1'b1, 4'd15},
        {16'h00C0, 16'hFFFF, 1'b0, 1'b1, 4'd6},
        {16'h0081, 16'h0080, 1'b1, 1'b1, 4'd7},
        {16'hFFFF, 16'h0000, 1'b1, 1'b0, 4'd0}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [N-1:0] d, input logic sup);
        reg_en = 1'b1; reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; supv = sup;
        step();
        reg_en = 1'b0; reg_wr = 1'b0; supv = 1'b1;
    endtask

    task automatic rd(input logic [1:0] sel, input logic sup, output logic [N-1:0] d);
        reg_en = 1'b1; reg_wr = 1'b0; reg_sel = sel; supv = sup;
        #1;
        d = reg_rdata;
        reg_en = 1'b0; supv = 1'b1;
        #1;
    endtask

    task automatic pulse_gie(input logic s, input logic c);
        gie_set = s; gie_clr = c;
        step();
        gie_set = 1'b0; gie_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        rd(2'd0, 1'b1, v); chk("R1 latch", 32'(v), 32'h0);
        rd(2'd1, 1'b1, v); chk("R1 mask", 32'(v), 32'h0);
        rd(2'd2, 1'b1, v); chk("R1 pend", 32'(v), 32'h0);
        chk("R1 req", 32'(req), 32'h0);
        wr(2'd0, 16'h0100, 1'b1);
        wr(2'd1, 16'hFFFF, 1'b1);
        chk("R1 gie off", 32'(req), 32'h0);

        // Table walk: R3 R4 R9 selection patterns
        for (int k = 0; k < NV; k++) begin
            wr(2'd1, 16'h0000, 1'b1);
            wr(2'd0, VEC[k][37:22], 1'b1);
            wr(2'd1, VEC[k][21:6], 1'b1);
            pulse_gie(VEC[k][5], !VEC[k][5]);
            chk($sformatf("R4 req vec%0d", k), 32'(req), 32'(VEC[k][4]));
            if (VEC[k][4]) chk($sformatf("R4 id vec%0d", k), 32'(req_id), 32'(VEC[k][3:0]));
            rd(2'd0, 1'b1, v);
            chk($sformatf("R3 latch kept vec%0d", k), 32'(v), 32'(VEC[k][37:22]));
        end

        // Clean and enable everything
        wr(2'd1, 16'h0000, 1'b1);
        wr(2'd0, 16'h0000, 1'b1);
        wr(2'd1, 16'hFFFF, 1'b1);
        pulse_gie(1'b1, 1'b0);

        // R2 / R6 latency
        evt_in[5] = 1'b1;
        step();
        rd(2'd0, 1'b1, v); chk("R2 not yet", 32'(v), 32'h0);
        step();
        rd(2'd0, 1'b1, v); chk("R2 latched", 32'(v), 32'h0020);
        chk("R4 req5", 32'(req), 32'h1);
        chk("R4 id5", 32'(req_id), 32'd5);
        ack = 1'b1;
        step();
        ack = 1'b0;
        rd(2'd2, 1'b1, v); chk("R6 pend at 3", 32'(v), 32'h0020);
        rd(2'd0, 1'b1, v); chk("R6 latch cleared", 32'(v), 32'h0);
        chk("R6 req low", 32'(req), 32'h0);
        repeat (3) step();
        rd(2'd0, 1'b1, v); chk("R2 level once", 32'(v), 32'h0);

        // R7 queued edge, R5 blocked by own level
        evt_in[5] = 1'b0;
        step();
        evt_in[5] = 1'b1;
        step(); step();
        rd(2'd0, 1'b1, v); chk("R7 requeued", 32'(v), 32'h0020);
        chk("R5 no self preempt", 32'(req), 32'h0);
        evt_in[3] = 1'b1;
        step(); step();
        chk("R5 preempt req", 32'(req), 32'h1);
        chk("R5 preempt id", 32'(req_id), 32'd3);
        ack = 1'b1;
        step();
        ack = 1'b0;
        rd(2'd2, 1'b1, v); chk("R6 nested pend", 32'(v), 32'h0028);
        rd(2'd0, 1'b1, v); chk("R6 latch3 clr", 32'(v), 32'h0020);
        chk("R5 blocked", 32'(req), 32'h0);

        // R8 return clears innermost level
        ret = 1'b1; step(); ret = 1'b0;
        rd(2'd2, 1'b1, v); chk("R8 inner cleared", 32'(v), 32'h0020);
        chk("R8 still blocked", 32'(req), 32'h0);
        ret = 1'b1; step(); ret = 1'b0;
        rd(2'd2, 1'b1, v); chk("R8 outer cleared", 32'(v), 32'h0);
        chk("R7 queued req", 32'(req), 32'h1);
        chk("R7 queued id", 32'(req_id), 32'd5);
        ack = 1'b1; step(); ack = 1'b0;
        ret = 1'b1; step(); ret = 1'b0;
        evt_in = '0;
        step(); step();
        rd(2'd2, 1'b1, v); chk("R8 empty", 32'(v), 32'h0);

        // R10 latch write honours mask
        wr(2'd1, 16'h00F0, 1'b1);
        wr(2'd0, 16'hFFFF, 1'b1);
        rd(2'd0, 1'b1, v); chk("R10 masked kept", 32'(v), 32'hFF0F);
        chk("R3 masked no req", 32'(req), 32'h0);
        wr(2'd1, 16'hFFFF, 1'b1);
        wr(2'd0, 16'h0000, 1'b1);
        rd(2'd0, 1'b1, v); chk("R10 all masked", 32'(v), 32'hFF0F);
        wr(2'd1, 16'h0000, 1'b1);
        wr(2'd0, 16'h0000, 1'b1);

        // R12 user mode
        wr(2'd1, 16'hAAAA, 1'b0);
        rd(2'd1, 1'b1, v); chk("R12 user write ignored", 32'(v), 32'h0);
        wr(2'd0, 16'h0003, 1'b1);
        rd(2'd0, 1'b0, v); chk("R12 user read zero", 32'(v), 32'h0);
        rd(2'd0, 1'b1, v); chk("R12 super read", 32'(v), 32'h0003);
        reg_sel = 2'd0; supv = 1'b1; reg_en = 1'b0; #1;
        chk("R12 idle read zero", 32'(reg_rdata), 32'h0);
        wr(2'd0, 16'h0000, 1'b1);

        // R11 pending read-only, select 3
        wr(2'd2, 16'hFFFF, 1'b1);
        rd(2'd2, 1'b1, v); chk("R11 pend write ignored", 32'(v), 32'h0);
        rd(2'd3, 1'b1, v); chk("R11 sel3 zero", 32'(v), 32'h0);
        wr(2'd1, 16'h5A5A, 1'b1);
        rd(2'd1, 1'b1, v); chk("R11 mask write", 32'(v), 32'h5A5A);

        // R9 global enable commands
        wr(2'd1, 16'h0000, 1'b1);
        wr(2'd0, 16'h0100, 1'b1);
        wr(2'd1, 16'hFFFF, 1'b1);
        chk("R9 on req", 32'(req), 32'h1);
        pulse_gie(1'b1, 1'b1);
        chk("R9 clear wins", 32'(req), 32'h0);
        pulse_gie(1'b1, 1'b0);
        chk("R9 set req", 32'(req), 32'h1);
        chk("R9 set id", 32'(req_id), 32'd8);
        pulse_gie(1'b0, 1'b1);
        chk("R9 cleared", 32'(req), 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule